// File: doc/BRIEF.md
# Receive-Side Link Word Decoder with Voted Control Bits

This block sits behind the bit aligner of a serial video link receiver. Each cycle that the word strobe is high, it takes one aligned 20-bit word and decides what kind of word it is. Two reserved codes mark the change of phase, one for control to video and one for video to control. Every other word is read as a video word or a control word, depending on the last phase code seen. The decoder starts in the control phase.

A video word has two encoding flags in bits 0 and 1 and eighteen symbols in bits 2 to 19. The symbols are restored, which means they are inverted when the polarity flag in bit 1 is set. A control word has nine control bits. The first five of them arrive as three copies each, and the decoder recovers each one by two-of-three voting. The last four arrive once each and pass straight through. The video outputs and the control outputs each keep their last decoded value until a word of their own kind arrives. A data-enable output shows whether the most recent data word was video. An error pulse, which a parameter can leave out, reports any vote that was not unanimous.

Top module: `ctrl_word_decoder`

## Requirements
- R1: While reset is high, and in the first cycle after it, all outputs are zero and the decoder is in the control phase.
- R2: In a control word, control bit k (k = 0..4) is the value shared by at least two of its copies in word bits 3k+1, 3k+2 and 3k+3. It appears on ctl_o[k].
- R3: In a control word, word bits 16, 17, 18 and 19 appear without change on ctl_o[5], ctl_o[6], ctl_o[7] and ctl_o[8].
- R4: In a video word, bits 2..19 appear on vid_o[17:0] (bit 2 on vid_o[0]). If bit 1 is 1, these bits are inverted first. Bit 0 has no effect on any output.
- R5: The word 0xFFC00 switches the phase to video. The word 0x003FF switches it to control. Neither code changes any output.
- R6: ctl_o holds its value during video words and phase codes.
- R7: vid_o holds its value during control words and phase codes.
- R8: de_o becomes 1 with every video word and 0 with every control word. It holds its value on phase codes.
- R9: With the error flag enabled, err_o is 1 for exactly the one cycle after a control word in which at least one voted triplet is not unanimous. At all other times it is 0.
- R10: Outputs change one clock after the word is accepted. A cycle with word_vld low changes no output except clearing err_o.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Word clock |
| rst | input | 1 | Synchronous reset, active high |
| word_vld | input | 1 | An aligned word is present this cycle |
| word_in | input | 20 | Aligned word, bit 0 first on the line |
| vid_o | output | 18 | Held restored video symbols |
| ctl_o | output | 9 | Held recovered control bits |
| de_o | output | 1 | 1 while the latest data word was video |
| err_o | output | 1 | One-cycle pulse on a non-unanimous vote |

## Verification
The bench builds the decoder with its default parameters: eighteen symbols, five voted control bits, four direct control bits and the error flag on. With this build the bench can reach every copy position of every triplet, so it flips a single copy in each triplet in turn and also flips two copies at once. It can also test inversion of the full symbol field and both phase codes. The bench places idle cycles and back-to-back phase codes between data words. This shows that each output group holds its value and that de_o changes only on data words.

// File: rtl/ctrl_dec_pkg.sv
package ctrl_dec_pkg;

  typedef enum logic {
    PH_CTRL = 1'b0,
    PH_VID  = 1'b1
  } phase_t;

  typedef enum logic [1:0] {
    WK_CTRL = 2'd0,
    WK_VID  = 2'd1,
    WK_TO_V = 2'd2,
    WK_TO_C = 2'd3
  } wkind_t;

  // two-of-three vote
  function automatic logic vote3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction

  // all three copies agree
  function automatic logic same3(input logic a, input logic b, input logic c);
    return (a == b) && (b == c);
  endfunction

endpackage

// File: rtl/word_classifier.sv
module word_classifier
  import ctrl_dec_pkg::*;
#(
  parameter int          WORD_W  = 20,
  parameter logic [19:0] CODE_TV = 20'hFFC00,
  parameter logic [19:0] CODE_TC = 20'h003FF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              word_vld,
  input  logic [WORD_W-1:0] word_in,
  output wkind_t            kind,
  output phase_t            phase
);

  logic hit_tv, hit_tc;

  assign hit_tv = (word_in == CODE_TV[WORD_W-1:0]);
  assign hit_tc = (word_in == CODE_TC[WORD_W-1:0]);

  always_comb begin
    if (hit_tv)              kind = WK_TO_V;
    else if (hit_tc)         kind = WK_TO_C;
    else if (phase == PH_VID) kind = WK_VID;
    else                     kind = WK_CTRL;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= PH_CTRL;
    end else if (word_vld) begin
      if (hit_tv)      phase <= PH_VID;
      else if (hit_tc) phase <= PH_CTRL;
    end
  end

  // R5: phase codes steer later words
  a_r5_to_video : assert property (@(posedge clk) disable iff (rst)
    (word_vld && word_in == CODE_TV[WORD_W-1:0]) |=> (phase == PH_VID));
  a_r5_to_ctrl : assert property (@(posedge clk) disable iff (rst)
    (word_vld && word_in == CODE_TC[WORD_W-1:0]) |=> (phase == PH_CTRL));

endmodule

// File: rtl/video_unpacker.sv
module video_unpacker #(
  parameter int SYM_W = 18,
  localparam int VW_W = SYM_W + 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [VW_W-1:0]  word_in,
  output logic [SYM_W-1:0] vid_o
);

  logic             pol;
  logic [SYM_W-1:0] sym;

  assign pol = word_in[1];
  assign sym = word_in[VW_W-1:2];

  always_ff @(posedge clk) begin
    if (rst)       vid_o <= '0;
    else if (load) vid_o <= pol ? ~sym : sym;
  end

  // R7: video outputs hold outside video words
  a_r7_vid_hold : assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(vid_o));

endmodule

// File: rtl/ctrl_voter.sv
module ctrl_voter
  import ctrl_dec_pkg::*;
#(
  parameter int VOTE_N   = 5,
  parameter int DIRECT_N = 4,
  parameter bit ERR_EN   = 1'b1,
  localparam int CW_W    = 1 + 3*VOTE_N + DIRECT_N,
  localparam int CTL_N   = VOTE_N + DIRECT_N,
  localparam int DIR_LO  = 1 + 3*VOTE_N
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CW_W-1:0]  word_in,
  output logic [CTL_N-1:0] ctl_o,
  output logic             err_o
);

  logic [CTL_N-1:0]  ctl_nx;
  logic [VOTE_N-1:0] agree;

  for (genvar k = 0; k < VOTE_N; k++) begin : g_vote
    assign ctl_nx[k] = vote3(word_in[3*k+1], word_in[3*k+2], word_in[3*k+3]);
    assign agree[k]  = same3(word_in[3*k+1], word_in[3*k+2], word_in[3*k+3]);
  end

  for (genvar d = 0; d < DIRECT_N; d++) begin : g_direct
    assign ctl_nx[VOTE_N+d] = word_in[DIR_LO+d];
  end

  always_ff @(posedge clk) begin
    if (rst)       ctl_o <= '0;
    else if (load) ctl_o <= ctl_nx;
  end

  if (ERR_EN) begin : g_err
    always_ff @(posedge clk) begin
      if (rst) err_o <= 1'b0;
      else     err_o <= load && !(&agree);
    end
  end else begin : g_no_err
    assign err_o = 1'b0;
  end

  // R6: control outputs hold outside control words
  a_r6_ctl_hold : assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(ctl_o));
  // R9: error pulse only follows a control word
  a_r9_err_after_load : assert property (@(posedge clk) disable iff (rst)
    !load |=> !err_o);

endmodule

// File: rtl/ctrl_word_decoder.sv
module ctrl_word_decoder
  import ctrl_dec_pkg::*;
#(
  parameter int          SYM_W    = 18,
  parameter int          VOTE_N   = 5,
  parameter int          DIRECT_N = 4,
  parameter bit          ERR_EN   = 1'b1,
  parameter logic [19:0] CODE_TV  = 20'hFFC00,
  parameter logic [19:0] CODE_TC  = 20'h003FF,
  localparam int WORD_W = SYM_W + 2,
  localparam int CTL_N  = VOTE_N + DIRECT_N
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              word_vld,
  input  logic [WORD_W-1:0] word_in,
  output logic [SYM_W-1:0]  vid_o,
  output logic [CTL_N-1:0]  ctl_o,
  output logic              de_o,
  output logic              err_o
);

  wkind_t kind;
  phase_t phase;
  logic   ld_vid, ld_ctl;

  word_classifier #(
    .WORD_W (WORD_W),
    .CODE_TV(CODE_TV),
    .CODE_TC(CODE_TC)
  ) u_cls (
    .clk     (clk),
    .rst     (rst),
    .word_vld(word_vld),
    .word_in (word_in),
    .kind    (kind),
    .phase   (phase)
  );

  assign ld_vid = word_vld && (kind == WK_VID);
  assign ld_ctl = word_vld && (kind == WK_CTRL);

  video_unpacker #(.SYM_W(SYM_W)) u_vid (
    .clk    (clk),
    .rst    (rst),
    .load   (ld_vid),
    .word_in(word_in),
    .vid_o  (vid_o)
  );

  ctrl_voter #(
    .VOTE_N  (VOTE_N),
    .DIRECT_N(DIRECT_N),
    .ERR_EN  (ERR_EN)
  ) u_ctl (
    .clk    (clk),
    .rst    (rst),
    .load   (ld_ctl),
    .word_in(word_in),
    .ctl_o  (ctl_o),
    .err_o  (err_o)
  );

  always_ff @(posedge clk) begin
    if (rst)         de_o <= 1'b0;
    else if (ld_vid) de_o <= 1'b1;
    else if (ld_ctl) de_o <= 1'b0;
  end

  // R8: phase codes leave de_o alone
  a_r8_de_on_code : assert property (@(posedge clk) disable iff (rst)
    (word_vld && (word_in == CODE_TV[WORD_W-1:0] || word_in == CODE_TC[WORD_W-1:0]))
      |=> $stable(de_o));
  // R10: idle cycles change no held output
  a_r10_idle_hold : assert property (@(posedge clk) disable iff (rst)
    !word_vld |=> ($stable(de_o) && $stable(vid_o) && $stable(ctl_o)));
  // R8: a video data word raises de_o
  a_r8_de_rises : assert property (@(posedge clk) disable iff (rst)
    (word_vld && phase == PH_VID && word_in != CODE_TV[WORD_W-1:0]
      && word_in != CODE_TC[WORD_W-1:0]) |=> de_o);

endmodule

// File: tb/sim_ctrl_word_decoder.sv
module sim_ctrl_word_decoder;

  localparam logic [19:0] TV = 20'hFFC00;
  localparam logic [19:0] TC = 20'h003FF;

  typedef struct {
    int          due;
    string       req;
    logic [17:0] vid;
    logic [8:0]  ctl;
    logic        de;
    logic        err;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        word_vld = 1'b0;
  logic [19:0] word_in = '0;
  logic [17:0] vid_o;
  logic [8:0]  ctl_o;
  logic        de_o, err_o;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit done   = 0;

  exp_t q[$];

  logic        m_ph  = 1'b0;
  logic [17:0] m_vid = '0;
  logic [8:0]  m_ctl = '0;
  logic        m_de  = 1'b0;
  logic        m_err = 1'b0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  ctrl_word_decoder u0 (
    .clk(clk), .rst(rst), .word_vld(word_vld), .word_in(word_in),
    .vid_o(vid_o), .ctl_o(ctl_o), .de_o(de_o), .err_o(err_o)
  );

  function automatic logic [19:0] mk_ctl(input logic [8:0] c, input logic [14:0] flip, input logic en0);
    logic [19:0] w;
    w[0] = en0;
    for (int k = 0; k < 5; k++) begin
      w[3*k+1] = c[k] ^ flip[3*k];
      w[3*k+2] = c[k] ^ flip[3*k+1];
      w[3*k+3] = c[k] ^ flip[3*k+2];
    end
    w[19:16] = c[8:5];
    return w;
  endfunction

  function automatic logic [19:0] mk_vid(input logic [17:0] s, input logic en1, input logic en0);
    return {s, en1, en0};
  endfunction

  task automatic send(input logic vld, input logic [19:0] w, input string req);
    exp_t e;
    @(posedge clk);
    #2;
    word_vld = vld;
    word_in  = w;
    m_err = 1'b0;
    if (vld) begin
      if (w == TV) m_ph = 1'b1;
      else if (w == TC) m_ph = 1'b0;
      else if (m_ph) begin
        m_vid = w[1] ? ~w[19:2] : w[19:2];
        m_de  = 1'b1;
      end else begin
        for (int k = 0; k < 5; k++) begin
          int n;
          n = int'(w[3*k+1]) + int'(w[3*k+2]) + int'(w[3*k+3]);
          m_ctl[k] = (n >= 2);
          if (n == 1 || n == 2) m_err = 1'b1;
        end
        m_ctl[8:5] = w[19:16];
        m_de = 1'b0;
      end
    end
    e.due = cyc + 1;
    e.req = req;
    e.vid = m_vid;
    e.ctl = m_ctl;
    e.de  = m_de;
    e.err = m_err;
    q.push_back(e);
  endtask

  always @(negedge clk) begin
    while (q.size() > 0 && q[0].due == cyc) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (vid_o !== e.vid || ctl_o !== e.ctl || de_o !== e.de || err_o !== e.err) begin
        fails++;
        $display("FAIL %s: got vid=%h ctl=%h de=%b err=%b, expected vid=%h ctl=%h de=%b err=%b",
                 e.req, vid_o, ctl_o, de_o, err_o, e.vid, e.ctl, e.de, e.err);
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst = 1'b0;
    @(negedge clk);
    checks++;
    if (vid_o !== '0 || ctl_o !== '0 || de_o !== 1'b0 || err_o !== 1'b0) begin
      fails++;
      $display("FAIL R1: got vid=%h ctl=%h de=%b err=%b, expected all zero",
               vid_o, ctl_o, de_o, err_o);
    end
    // control phase from reset: unanimous triplets and direct bits
    send(1, mk_ctl(9'h1A5, 15'h0, 1'b0), "R2 R3 unanimous");
    send(1, mk_ctl(9'h05A, 15'h0, 1'b1), "R3 direct bits, EN0 set");
    // one copy flipped at each position of each triplet
    for (int p = 0; p < 15; p++)
      send(1, mk_ctl(9'h0F3 ^ 9'(p), 15'(1) << p, 1'b0), "R2 R9 single copy off");
    // two copies flipped: vote follows the majority of the word
    send(1, mk_ctl(9'h000, 15'b000_000_011_000_110, 1'b0), "R2 R9 double copy off");
    send(1, mk_ctl(9'h1FF, 15'h0, 1'b0), "R9 clean word no error");
    send(0, 20'hABCDE, "R10 idle");
    send(0, 20'h12345, "R10 idle err clears");
    // switch to video
    send(1, TV, "R5 R6 R8 code to video");
    send(1, mk_vid(18'h2B3C4, 1'b0, 1'b0), "R4 R8 video plain");
    send(1, mk_vid(18'h2B3C4, 1'b1, 1'b0), "R4 video inverted");
    send(1, mk_vid(18'h3FFFF, 1'b1, 1'b1), "R4 full inversion, EN0 no effect");
    send(1, mk_vid(18'h15555, 1'b0, 1'b1), "R4 EN0 no effect");
    send(0, 20'hFFFFF, "R10 idle in video");
    send(1, TV, "R5 repeated code");
    send(1, mk_vid(18'h0F0F0, 1'b0, 1'b0), "R6 ctl held in video");
    // back to control
    send(1, TC, "R5 R7 R8 code to control");
    send(1, TV, "R5 back-to-back codes");
    send(1, TC, "R5 R8 de holds on codes");
    send(1, mk_ctl(9'h123, 15'h0, 1'b0), "R7 R8 control after codes");
    send(1, mk_ctl(9'h0AA, 15'b100_000_000_000_000, 1'b0), "R2 R7 vid held");
    send(1, TV, "R5 to video");
    send(1, mk_vid(18'h00001, 1'b1, 1'b0), "R4 R8 video again");
    send(1, TC, "R5 to control");
    send(1, mk_ctl(9'h155, 15'h0, 1'b0), "R3 R8 control again");
    send(0, 20'h0, "R10 final idle");
    repeat (4) @(posedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got no completion, expected end of stimulus");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule